// File: doc/BRIEF.md
# Coalesced Request Table

This block gathers the per-lane memory packets of a wide instruction into cache-line requests. Each packet names its instruction, its line address, its lane and its kind. A packet that targets a line already requested by the same instruction, while that request is still gathering, is attached to that request. Any other packet claims a free slot, but only while the global count of live requests is below its limit. When the limit is reached, the packet is refused and the requester keeps it. Each slot records the instruction, the line, the kind, the lane mask of its attached packets, the first lane attached (the representative packet) and the cycle in which it was issued.

Each slot runs a four-state machine: FREE, OPEN (gathering lanes), SEALED (waiting to issue) and ISSUED (waiting for completion). The transitions are:
- FREE to OPEN on allocation.
- FREE to SEALED on allocation by the last packet of an instruction.
- OPEN to SEALED when the instruction's last packet is accepted.
- SEALED to ISSUED on the downstream handshake.
- ISSUED to FREE on a matching completion.

Requests to the same line from different instructions wait in age order. Only the oldest of them may issue. A completion carries a line address and releases every lane of the matching issued request at once, one cycle later.

Top module: `cq_mshr_table`

## Requirements
- R1: After reset the table is empty: `out_count` is 0, `req_valid` and `rel_valid` are low, and `pkt_ready` is high.
- R2: A packet whose instruction and line match an OPEN slot is accepted into that slot. Its lane is added to the mask and `out_count` does not change.
- R3: A packet with no matching OPEN slot is accepted into a new slot only when `out_count` is below `MAX_OUT`. The count rises by one after that edge.
- R4: With `out_count` equal to `MAX_OUT`, a packet with no matching OPEN slot sees `pkt_ready` low and changes nothing. A matching packet is still accepted.
- R5: A slot cannot issue until a packet with `pkt_last` high for its instruction has been accepted.
- R6: The kind field is 2 bits: 00 load, 01 store, 10 atomic, 11 null. A request carries the kind of the packet that allocated it.
- R7: Among live slots with the same line, only the oldest may issue. A younger one issues only after the older one completes.
- R8: While `req_valid` is high and `req_ready` is low, the offered request stays the same, even if another slot becomes eligible.
- R9: A completion whose line matches an ISSUED slot frees that slot. On the next cycle it raises `rel_valid` with that slot's instruction, kind and full lane mask, and `out_count` falls by one.
- R10: A completion whose line matches no ISSUED slot produces no release and leaves the count unchanged.
- R11: `rel_lane` and `req_lane` give the first lane attached to the request.
- R12: `rel_stamp` is the value of the cycle counter (cycles since reset) in the cycle of the issue handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet accepted this cycle |
| pkt_inst | input | IW | Instruction sequence number |
| pkt_line | input | AW | Cache-line address |
| pkt_lane | input | log2(LANES) | Lane index |
| pkt_type | input | 2 | Access kind |
| pkt_last | input | 1 | Last packet of the instruction |
| req_valid | output | 1 | Request offered downstream |
| req_ready | input | 1 | Downstream takes the request |
| req_line | output | AW | Request line |
| req_type | output | 2 | Request kind |
| req_inst | output | IW | Request instruction |
| req_lane | output | log2(LANES) | Representative lane |
| cpl_valid | input | 1 | Completion arrives |
| cpl_line | input | AW | Completed line |
| rel_valid | output | 1 | Release of packets |
| rel_inst | output | IW | Released instruction |
| rel_type | output | 2 | Released kind |
| rel_mask | output | LANES | Released lanes |
| rel_lane | output | log2(LANES) | Representative lane |
| rel_stamp | output | TW | Issue cycle of released request |
| out_count | output | log2(MAX_OUT+1) | Global live-request count |

## Verification
The table vectors feed lane packets in several patterns:
- a repeated line within one instruction, which must merge;
- a new line, which must allocate;
- the same line from a later instruction, which must allocate a second slot rather than merge;
- a new line at the limit, which must be refused, next to a matching lane at the limit, which must still merge.

Directed steps then stall the downstream side while a lower slot becomes eligible, to separate holding from re-picking. They complete a line that nothing has issued. They drain duplicate lines to show that age order, not slot index, decides which request goes first.

// File: rtl/cq_pkg.sv
package cq_pkg;
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_SEALED = 2'd2,
        ST_ISSUED = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        RK_LOAD   = 2'b00,
        RK_STORE  = 2'b01,
        RK_ATOMIC = 2'b10,
        RK_NULL   = 2'b11
    } req_kind_e;
endpackage

// File: rtl/cq_pick.sv
module cq_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cq_slot.sv
module cq_slot
    import cq_pkg::*;
#(
    parameter int IW    = 8,
    parameter int AW    = 16,
    parameter int LANES = 8,
    parameter int LW    = 3,
    parameter int TW    = 16,
    parameter int N     = 4,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_alloc,
    input  logic             do_merge,
    input  logic             do_seal,
    input  logic             do_issue,
    input  logic             do_free,
    input  logic [IW-1:0]    in_inst,
    input  logic [AW-1:0]    in_line,
    input  logic [LW-1:0]    in_lane,
    input  req_kind_e        in_kind,
    input  logic [TW-1:0]    in_stamp,
    input  logic [N-1:0]     alloc_vec,
    input  logic [N-1:0]     valid_vec,
    output slot_state_e      st,
    output logic [IW-1:0]    inst,
    output logic [AW-1:0]    line,
    output req_kind_e        kind,
    output logic [LANES-1:0] mask,
    output logic [LW-1:0]    first,
    output logic [TW-1:0]    stamp,
    output logic [N-1:0]     older
);
    slot_state_e st_q, st_d;
    localparam logic [N-1:0] SELF = N'(1) << IDX;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FREE:   if (do_alloc) st_d = do_seal ? ST_SEALED : ST_OPEN;
            ST_OPEN:   if (do_seal)  st_d = ST_SEALED;
            ST_SEALED: if (do_issue) st_d = ST_ISSUED;
            ST_ISSUED: if (do_free)  st_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inst  <= '0;
            line  <= '0;
            kind  <= RK_NULL;
            mask  <= '0;
            first <= '0;
            stamp <= '0;
            older <= '0;
        end else begin
            if (do_alloc) begin
                inst  <= in_inst;
                line  <= in_line;
                kind  <= in_kind;
                mask  <= LANES'(1) << in_lane;
                first <= in_lane;
                older <= valid_vec & ~SELF;
            end else begin
                older <= older & ~alloc_vec;
                if (do_merge) mask <= mask | (LANES'(1) << in_lane);
            end
            if (do_issue) stamp <= in_stamp;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/cq_mshr_table.sv
module cq_mshr_table
    import cq_pkg::*;
#(
    parameter int IW      = 8,
    parameter int AW      = 16,
    parameter int LANES   = 8,
    parameter int TW      = 16,
    parameter int MAX_OUT = 4,
    localparam int LW     = $clog2(LANES),
    localparam int CW     = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    output logic             pkt_ready,
    input  logic [IW-1:0]    pkt_inst,
    input  logic [AW-1:0]    pkt_line,
    input  logic [LW-1:0]    pkt_lane,
    input  logic [1:0]       pkt_type,
    input  logic             pkt_last,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [AW-1:0]    req_line,
    output logic [1:0]       req_type,
    output logic [IW-1:0]    req_inst,
    output logic [LW-1:0]    req_lane,
    input  logic             cpl_valid,
    input  logic [AW-1:0]    cpl_line,
    output logic             rel_valid,
    output logic [IW-1:0]    rel_inst,
    output logic [1:0]       rel_type,
    output logic [LANES-1:0] rel_mask,
    output logic [LW-1:0]    rel_lane,
    output logic [TW-1:0]    rel_stamp,
    output logic [CW-1:0]    out_count
);
    localparam int N = MAX_OUT;

    slot_state_e      st_a    [N];
    logic [IW-1:0]    inst_a  [N];
    logic [AW-1:0]    line_a  [N];
    req_kind_e        kind_a  [N];
    logic [LANES-1:0] mask_a  [N];
    logic [LW-1:0]    first_a [N];
    logic [TW-1:0]    stamp_a [N];
    logic [N-1:0]     older_a [N];

    logic [N-1:0] valid_vec, free_vec, hit_vec, open_inst_vec, head_vec, elig_vec;
    logic [N-1:0] free_gnt, elig_gnt, alloc_vec, merge_vec, seal_vec;
    logic [N-1:0] sel_vec, sel_q, issue_vec, cpl_vec;
    logic         hold_q, accept, hit_any;
    logic [CW-1:0] cnt_q;
    logic [TW-1:0] cyc_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            valid_vec[i]     = (st_a[i] != ST_FREE);
            free_vec[i]      = (st_a[i] == ST_FREE);
            open_inst_vec[i] = (st_a[i] == ST_OPEN) && (inst_a[i] == pkt_inst);
            hit_vec[i]       = open_inst_vec[i] && (line_a[i] == pkt_line);
            cpl_vec[i]       = cpl_valid && (st_a[i] == ST_ISSUED) && (line_a[i] == cpl_line);
            head_vec[i]      = 1'b1;
            for (int j = 0; j < N; j++)
                if (older_a[i][j] && valid_vec[j] && (line_a[j] == line_a[i]))
                    head_vec[i] = 1'b0;
            elig_vec[i] = (st_a[i] == ST_SEALED) && head_vec[i];
        end
    end

    cq_pick #(.W(N)) u_free_pick (.req(free_vec), .gnt(free_gnt));
    cq_pick #(.W(N)) u_elig_pick (.req(elig_vec), .gnt(elig_gnt));

    assign hit_any   = |hit_vec;
    assign pkt_ready = hit_any || (cnt_q < CW'(MAX_OUT));
    assign accept    = pkt_valid && pkt_ready;
    assign merge_vec = accept ? hit_vec : '0;
    assign alloc_vec = (accept && !hit_any) ? free_gnt : '0;
    assign seal_vec  = (accept && pkt_last) ? (open_inst_vec | alloc_vec) : '0;
    assign sel_vec   = hold_q ? sel_q : elig_gnt;
    assign req_valid = |sel_vec;
    assign issue_vec = (req_valid && req_ready) ? sel_vec : '0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            cq_slot #(
                .IW(IW), .AW(AW), .LANES(LANES), .LW(LW), .TW(TW), .N(N), .IDX(g)
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .do_alloc (alloc_vec[g]),
                .do_merge (merge_vec[g]),
                .do_seal  (seal_vec[g]),
                .do_issue (issue_vec[g]),
                .do_free  (cpl_vec[g]),
                .in_inst  (pkt_inst),
                .in_line  (pkt_line),
                .in_lane  (pkt_lane),
                .in_kind  (req_kind_e'(pkt_type)),
                .in_stamp (cyc_q),
                .alloc_vec(alloc_vec),
                .valid_vec(valid_vec),
                .st       (st_a[g]),
                .inst     (inst_a[g]),
                .line     (line_a[g]),
                .kind     (kind_a[g]),
                .mask     (mask_a[g]),
                .first    (first_a[g]),
                .stamp    (stamp_a[g]),
                .older    (older_a[g])
            );
        end
    endgenerate

    always_comb begin
        req_line = '0;
        req_type = '0;
        req_inst = '0;
        req_lane = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_vec[i]) begin
                req_line = req_line | line_a[i];
                req_type = req_type | kind_a[i];
                req_inst = req_inst | inst_a[i];
                req_lane = req_lane | first_a[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            sel_q  <= '0;
            cnt_q  <= '0;
            cyc_q  <= '0;
        end else begin
            hold_q <= req_valid && !req_ready;
            sel_q  <= sel_vec;
            cyc_q  <= cyc_q + TW'(1);
            if ((|alloc_vec) && !(|cpl_vec))      cnt_q <= cnt_q + CW'(1);
            else if (!(|alloc_vec) && (|cpl_vec)) cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_valid <= 1'b0;
            rel_inst  <= '0;
            rel_type  <= '0;
            rel_mask  <= '0;
            rel_lane  <= '0;
            rel_stamp <= '0;
        end else begin
            rel_valid <= |cpl_vec;
            for (int i = 0; i < N; i++) begin
                if (cpl_vec[i]) begin
                    rel_inst  <= inst_a[i];
                    rel_type  <= kind_a[i];
                    rel_mask  <= mask_a[i];
                    rel_lane  <= first_a[i];
                    rel_stamp <= stamp_a[i];
                end
            end
        end
    end

    assign out_count = cnt_q;
endmodule

// File: rtl/cq_mshr_checker.sv
module cq_mshr_checker #(
    parameter int MAX_OUT = 4,
    parameter int CW      = 3,
    parameter int AW      = 16,
    parameter int IW      = 8,
    parameter int LANES   = 8,
    parameter int LW      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_ready,
    input logic [CW-1:0]    out_count,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AW-1:0]    req_line,
    input logic [IW-1:0]    req_inst,
    input logic             cpl_valid,
    input logic             rel_valid,
    input logic [LANES-1:0] rel_mask,
    input logic [LW-1:0]    rel_lane
);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CW'(MAX_OUT));

    assert_refuse_only_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_ready |-> out_count == CW'(MAX_OUT));

    assert_offer_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_line) && $stable(req_inst));

    assert_release_follows_cpl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> $past(cpl_valid));

    assert_release_has_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> rel_mask[rel_lane]);
endmodule

bind cq_mshr_table cq_mshr_checker #(
    .MAX_OUT(MAX_OUT), .CW(CW), .AW(AW), .IW(IW), .LANES(LANES), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_ready(pkt_ready), .out_count(out_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .req_inst(req_inst), .cpl_valid(cpl_valid), .rel_valid(rel_valid),
    .rel_mask(rel_mask), .rel_lane(rel_lane)
);

// File: tb/sim_cq_mshr_table.sv
module sim_cq_mshr_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0, pkt_ready, pkt_last = 1'b0;
    logic [7:0]  pkt_inst = '0;
    logic [15:0] pkt_line = '0;
    logic [2:0]  pkt_lane = '0;
    logic [1:0]  pkt_type = '0;
    logic        req_valid, req_ready = 1'b0;
    logic [15:0] req_line;
    logic [1:0]  req_type;
    logic [7:0]  req_inst;
    logic [2:0]  req_lane;
    logic        cpl_valid = 1'b0;
    logic [15:0] cpl_line = '0;
    logic        rel_valid;
    logic [7:0]  rel_inst;
    logic [1:0]  rel_type;
    logic [7:0]  rel_mask;
    logic [2:0]  rel_lane;
    logic [15:0] rel_stamp;
    logic [2:0]  out_count;

    int n_chk = 0, n_bad = 0;
    logic [15:0] bc = '0;
    logic [15:0] stamp0;

    localparam logic [15:0] LA = 16'h0100, LB = 16'h0104, LC = 16'h0200, LD = 16'h0300;

    typedef struct packed {
        logic [7:0]  inst;
        logic [15:0] line;
        logic [2:0]  lane;
        logic [1:0]  kind;
        logic        last;
        logic        exp_rdy;
        logic [2:0]  exp_cnt;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'd1, LA, 3'd0, 2'b00, 1'b0, 1'b1, 3'd1},
        '{8'd1, LA, 3'd3, 2'b00, 1'b0, 1'b1, 3'd1},
        '{8'd1, LB, 3'd1, 2'b00, 1'b0, 1'b1, 3'd2},
        '{8'd1, LA, 3'd5, 2'b00, 1'b1, 1'b1, 3'd2},
        '{8'd2, LA, 3'd2, 2'b01, 1'b0, 1'b1, 3'd3},
        '{8'd2, LC, 3'd4, 2'b01, 1'b0, 1'b1, 3'd4},
        '{8'd2, LC, 3'd6, 2'b01, 1'b0, 1'b1, 3'd4},
        '{8'd2, LD, 3'd7, 2'b01, 1'b1, 1'b0, 3'd4}
    };

    cq_mshr_table u0 (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bc <= '0;
        else        bc <= bc + 16'd1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] inst, input logic [15:0] line, input logic [2:0] lane,
                        input logic [1:0] kind, input logic last);
        pkt_valid = 1'b1; pkt_inst = inst; pkt_line = line;
        pkt_lane = lane; pkt_type = kind; pkt_last = last;
    endtask

    initial begin
        #(4 * 20000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 count", 32'(out_count), 0);
        chk("R1 req_valid", 32'(req_valid), 0);
        chk("R1 rel_valid", 32'(rel_valid), 0);
        chk("R1 pkt_ready", 32'(pkt_ready), 1);

        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            send(VEC[v].inst, VEC[v].line, VEC[v].lane, VEC[v].kind, VEC[v].last);
            #1 chk("R2/R3/R4 pkt_ready", 32'(pkt_ready), 32'(VEC[v].exp_rdy));
            @(posedge clk); #1;
            chk("R2/R3/R4 count", 32'(out_count), 32'(VEC[v].exp_cnt));
        end
        @(negedge clk) pkt_valid = 1'b0;
        #1;
        // R5 R6 R11: sealed inst1 line LA offered first
        chk("R5 req_valid", 32'(req_valid), 1);
        chk("R5 req_line", 32'(req_line), 32'(LA));
        chk("R6 req_type load", 32'(req_type), 0);
        chk("R11 req_lane", 32'(req_lane), 0);
        stamp0 = bc;
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        chk("R5 next req_line", 32'(req_line), 32'(LB));
        @(posedge clk);
        @(negedge clk) req_ready = 1'b0;
        #1 chk("R5 open slots stay unissued", 32'(req_valid), 0);

        // R10: completion for a line nothing issued
        cpl_valid = 1'b1; cpl_line = LC;
        @(posedge clk);
        @(negedge clk) cpl_valid = 1'b0;
        #1;
        chk("R10 no release", 32'(rel_valid), 0);
        chk("R10 count", 32'(out_count), 4);

        // R4: merge at the limit seals inst2
        send(8'd2, LC, 3'd0, 2'b01, 1'b1);
        #1 chk("R4 merge while full", 32'(pkt_ready), 1);
        @(posedge clk);
        @(negedge clk) pkt_valid = 1'b0;
        #1;
        chk("R7 younger dup blocked", 32'(req_line), 32'(LC));
        chk("R7 req_valid", 32'(req_valid), 1);

        // R9 R12: complete LA
        cpl_valid = 1'b1; cpl_line = LA;
        @(posedge clk);
        @(negedge clk) cpl_valid = 1'b0;
        #1;
        chk("R9 rel_valid", 32'(rel_valid), 1);
        chk("R9 rel_mask", 32'(rel_mask), 32'h29);
        chk("R9 rel_inst", 32'(rel_inst), 1);
        chk("R6 rel_type", 32'(rel_type), 0);
        chk("R11 rel_lane", 32'(rel_lane), 0);
        chk("R12 rel_stamp", 32'(rel_stamp), 32'(stamp0));
        chk("R9 count", 32'(out_count), 3);
        chk("R8 offer held", 32'(req_line), 32'(LC));

        // R3: allocation after release
        send(8'd3, LD, 3'd1, 2'b10, 1'b1);
        #1 chk("R3 pkt_ready", 32'(pkt_ready), 1);
        @(posedge clk);
        @(negedge clk) pkt_valid = 1'b0;
        #1;
        chk("R3 count", 32'(out_count), 4);
        chk("R9 single pulse", 32'(rel_valid), 0);
        chk("R8 held inst", 32'(req_inst), 2);

        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        chk("R6 atomic type", 32'(req_type), 2);
        chk("R6 atomic inst", 32'(req_inst), 3);
        @(posedge clk);
        @(negedge clk); #1;
        chk("R7 dup issues after older", 32'(req_line), 32'(LA));
        chk("R6 store type", 32'(req_type), 1);
        chk("R11 dup lane", 32'(req_lane), 2);
        @(posedge clk);
        @(negedge clk) req_ready = 1'b0;
        #1 chk("R7 drained", 32'(req_valid), 0);

        cpl_valid = 1'b1; cpl_line = LC;
        @(posedge clk);
        @(negedge clk) cpl_valid = 1'b0;
        #1;
        chk("R9 rel_mask LC", 32'(rel_mask), 32'h51);
        chk("R9 rel_inst LC", 32'(rel_inst), 2);
        chk("R11 rel_lane LC", 32'(rel_lane), 4);
        chk("R9 count LC", 32'(out_count), 3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule